// File: doc/BRIEF.md
# Host-to-Coprocessor Mailbox with Semaphore

This block is the register-mapped meeting point between a host CPU and an attached coprocessor. The host sends 16-bit commands through three independent command slots and collects 16-bit answers from three reply slots. Each slot holds a single entry and carries an occupancy flag. All six flags are gathered into a host-readable status word. The coprocessor side sees each pending command, takes it with a per-slot strobe, and posts replies with a per-slot strobe and data word.

A reset-hold bit in a configuration register keeps every slot empty while it is set. When the host clears that bit, the block runs a fixed start-up handshake. It posts a one into every reply slot. On the first host read of reply slot 2 after that, it posts a second, fixed word into slot 2 on the same edge. A 16-bit semaphore register sits alongside the slots. The host can OR bits into it, clear bits from it and mask it. A status bit records that an unmasked semaphore bit was raised.

Top module: `host_copro_mailbox`

## Requirements
- R1: A host write to 0x20, 0x28 or 0x30 stores the word in command slot 0, 1 or 2 when that slot is empty. The word appears on the coprocessor side and status bit 13, 14 or 15 is set.
- R2: A coprocessor take strobe on an occupied command slot empties it, and its status bit clears.
- R3: A host write to an occupied command slot is dropped, and the stored word stays unchanged.
- R4: A coprocessor post into an empty reply slot stores the word and sets status bit 10, 11 or 12. A host read at 0x24, 0x2C or 0x34 returns the word and empties the slot on that edge.
- R5: A host read of an empty reply slot returns 0x0000. A post into an occupied reply slot is dropped.
- R6: When a post and a host read hit an occupied reply slot on the same edge, the read returns the old word and the post is dropped, so the slot ends up empty.
- R7: Asynchronous reset clears every slot, flag, configuration bit and the semaphore. While bit 0 of the configuration register (0x08, readable) is 1, all slots are empty, and command writes and reply posts are ignored.
- R8: A configuration write that changes bit 0 from 1 to 0 posts 0x0001 into all three reply slots on that edge.
- R9: The first host read of occupied reply slot 2 after the boot of R8 returns 0x0001 and posts 0x0800 into slot 2 on the same edge. Later reads of slot 2 do not repeat this.
- R10: A write at 0x10 ORs the word into the semaphore, and a write at 0x18 clears the written bits. A read at 0x1C returns the semaphore, and a read at 0x1D returns its high byte in bits 7:0. The mask written at 0x14 reads back at 0x14.
- R11: Status bit 9 (status read at 0x0C) is set by a 0x10 write with at least one bit outside the mask. It is cleared when a 0x18 write brings the semaphore to zero. A set write whose bits are all masked leaves bit 9 unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_wr_i | input | 1 | Host write strobe |
| host_rd_i | input | 1 | Host read strobe (drives the reply-read side effects) |
| host_addr_i | input | 6 | Host register offset |
| host_wdata_i | input | 16 | Host write data |
| host_rdata_o | output | 16 | Host read data, combinational from the offset |
| cp_cmd_valid_o | output | 3 | Per-slot command pending |
| cp_cmd_data_o | output | 48 | Command words, slot i at bits 16i+15:16i |
| cp_take_i | input | 3 | Per-slot command take strobe |
| cp_post_i | input | 3 | Per-slot reply post strobe |
| cp_post_data_i | input | 48 | Reply words, slot i at bits 16i+15:16i |
| cp_reply_full_o | output | 3 | Per-slot reply occupied |

## Verification
Host read data is combinational, so the bench samples it in the same cycle that it raises the read strobe, before the edge at which the read's side effects happen. Every state change from a write, take, post, boot or chain lands on the edge that carries the strobe. The bench therefore drives strobes for one cycle on the falling edge and reads status on the next falling edge. Collisions are driven within one cycle so that the priorities of R3 and R6 are tested on a single edge.

// File: rtl/mbox_pkg.sv
`timescale 1ns/1ps
package mbox_pkg;
  localparam int NUM_SLOTS = 3;
  localparam int ADDR_W    = 6;

  localparam logic [ADDR_W-1:0] OFF_CFG    = 6'h08;
  localparam logic [ADDR_W-1:0] OFF_STAT   = 6'h0C;
  localparam logic [ADDR_W-1:0] OFF_SEMSET = 6'h10;
  localparam logic [ADDR_W-1:0] OFF_MASK   = 6'h14;
  localparam logic [ADDR_W-1:0] OFF_SEMCLR = 6'h18;
  localparam logic [ADDR_W-1:0] OFF_SEM_LO = 6'h1C;
  localparam logic [ADDR_W-1:0] OFF_SEM_HI = 6'h1D;

  localparam int ST_SEM_BIT = 9;
  localparam int ST_REP_LSB = 10;
  localparam int ST_CMD_LSB = 13;

  function automatic logic [ADDR_W-1:0] cmd_off(input int idx);
    return ADDR_W'(32'h20 + 32'(idx) * 8);
  endfunction

  function automatic logic [ADDR_W-1:0] rep_off(input int idx);
    return ADDR_W'(32'h24 + 32'(idx) * 8);
  endfunction
endpackage

// File: rtl/mbox_cmd_slot.sv
`timescale 1ns/1ps
module mbox_cmd_slot #(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              take_i,
  output logic              full_o,
  output logic [DATA_W-1:0] data_o
);
  logic              full_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (clr_i) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (full_q) begin
      if (take_i) full_q <= 1'b0; // write on the same edge is dropped
    end else if (wr_i) begin
      full_q <= 1'b1;
      data_q <= wdata_i;
    end
  end

  assign full_o = full_q;
  assign data_o = data_q;

  AST_CMD_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_q && wr_i && !clr_i |=> data_q == $past(data_q)); // R3

  AST_CMD_TAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_q && take_i |=> !full_q); // R2
endmodule

// File: rtl/mbox_reply_slot.sv
`timescale 1ns/1ps
module mbox_reply_slot #(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              force_i,
  input  logic [DATA_W-1:0] force_data_i,
  input  logic              rd_i,
  input  logic              post_i,
  input  logic [DATA_W-1:0] post_data_i,
  output logic              full_o,
  output logic [DATA_W-1:0] data_o
);
  logic              full_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (force_i) begin
      full_q <= 1'b1;
      data_q <= force_data_i;
    end else if (clr_i) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (full_q) begin
      if (rd_i) full_q <= 1'b0; // read wins over a colliding post
    end else if (post_i) begin
      full_q <= 1'b1;
      data_q <= post_data_i;
    end
  end

  assign full_o = full_q;
  assign data_o = data_q;

  AST_REP_READ_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_q && rd_i && !force_i && !clr_i |=> !full_q); // R6

  AST_REP_FULL_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_q && !rd_i && !force_i && !clr_i |=> full_q && data_q == $past(data_q)); // R5
endmodule

// File: rtl/mbox_sem.sv
`timescale 1ns/1ps
module mbox_sem #(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              set_i,
  input  logic              mask_wr_i,
  input  logic              clr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] sem_o,
  output logic [DATA_W-1:0] mask_o,
  output logic              flag_o
);
  logic [DATA_W-1:0] sem_q, mask_q, sem_d;
  logic              flag_q;

  always_comb begin
    sem_d = sem_q;
    if (set_i)      sem_d = sem_q | wdata_i;
    else if (clr_i) sem_d = sem_q & ~wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sem_q  <= '0;
      mask_q <= '0;
      flag_q <= 1'b0;
    end else begin
      sem_q <= sem_d;
      if (mask_wr_i) mask_q <= wdata_i;
      if (set_i && |(wdata_i & ~mask_q)) flag_q <= 1'b1;
      else if (clr_i && sem_d == '0)     flag_q <= 1'b0;
    end
  end

  assign sem_o  = sem_q;
  assign mask_o = mask_q;
  assign flag_o = flag_q;

  AST_SEM_FLAG_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sem_q == '0 |-> !flag_q); // R11

  AST_SEM_CLR_BITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (sem_q & $past(wdata_i)) == '0); // R10
endmodule

// File: rtl/host_copro_mailbox.sv
`timescale 1ns/1ps
module host_copro_mailbox
  import mbox_pkg::*;
#(
  parameter int          DATA_W    = 16,
  parameter logic [15:0] BOOT_VAL  = 16'h0001,
  parameter logic [15:0] CHAIN_VAL = 16'h0800
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        host_wr_i,
  input  logic                        host_rd_i,
  input  logic [ADDR_W-1:0]           host_addr_i,
  input  logic [DATA_W-1:0]           host_wdata_i,
  output logic [DATA_W-1:0]           host_rdata_o,
  output logic [NUM_SLOTS-1:0]        cp_cmd_valid_o,
  output logic [NUM_SLOTS*DATA_W-1:0] cp_cmd_data_o,
  input  logic [NUM_SLOTS-1:0]        cp_take_i,
  input  logic [NUM_SLOTS-1:0]        cp_post_i,
  input  logic [NUM_SLOTS*DATA_W-1:0] cp_post_data_i,
  output logic [NUM_SLOTS-1:0]        cp_reply_full_o
);
  localparam int CHAIN_SLOT = NUM_SLOTS - 1;

  logic [DATA_W-1:0]    cfg_q;
  logic                 armed_q;
  logic                 hold, boot, chain_fire;
  logic [NUM_SLOTS-1:0] cmd_full, rep_full, rep_rd;
  logic [DATA_W-1:0]    rep_data [NUM_SLOTS];
  logic [DATA_W-1:0]    sem, sem_mask;
  logic                 sem_flag;
  logic [15:0]          status;

  assign hold       = cfg_q[0];
  assign boot       = host_wr_i && host_addr_i == OFF_CFG && cfg_q[0] && !host_wdata_i[0];
  assign chain_fire = armed_q && rep_rd[CHAIN_SLOT] && rep_full[CHAIN_SLOT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      if (host_wr_i && host_addr_i == OFF_CFG) cfg_q <= host_wdata_i;
      if (boot)                                armed_q <= 1'b1;
      else if (hold || chain_fire)             armed_q <= 1'b0;
    end
  end

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    logic              force_en;
    logic [DATA_W-1:0] force_val;

    if (i == CHAIN_SLOT) begin : g_chain
      assign force_en  = boot || chain_fire;
      assign force_val = boot ? DATA_W'(BOOT_VAL) : DATA_W'(CHAIN_VAL);
    end else begin : g_plain
      assign force_en  = boot;
      assign force_val = DATA_W'(BOOT_VAL);
    end

    assign rep_rd[i] = host_rd_i && host_addr_i == rep_off(i);

    mbox_cmd_slot #(.DATA_W(DATA_W)) u_cmd (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clr_i   (hold),
      .wr_i    (host_wr_i && host_addr_i == cmd_off(i)),
      .wdata_i (host_wdata_i),
      .take_i  (cp_take_i[i]),
      .full_o  (cmd_full[i]),
      .data_o  (cp_cmd_data_o[i*DATA_W +: DATA_W])
    );

    mbox_reply_slot #(.DATA_W(DATA_W)) u_rep (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .clr_i        (hold),
      .force_i      (force_en),
      .force_data_i (force_val),
      .rd_i         (rep_rd[i]),
      .post_i       (cp_post_i[i]),
      .post_data_i  (cp_post_data_i[i*DATA_W +: DATA_W]),
      .full_o       (rep_full[i]),
      .data_o       (rep_data[i])
    );
  end

  mbox_sem #(.DATA_W(DATA_W)) u_sem (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (host_wr_i && host_addr_i == OFF_SEMSET),
    .mask_wr_i (host_wr_i && host_addr_i == OFF_MASK),
    .clr_i     (host_wr_i && host_addr_i == OFF_SEMCLR),
    .wdata_i   (host_wdata_i),
    .sem_o     (sem),
    .mask_o    (sem_mask),
    .flag_o    (sem_flag)
  );

  always_comb begin
    status = '0;
    status[ST_SEM_BIT] = sem_flag;
    status[ST_REP_LSB +: NUM_SLOTS] = rep_full;
    status[ST_CMD_LSB +: NUM_SLOTS] = cmd_full;
  end

  always_comb begin
    case (host_addr_i)
      OFF_CFG:    host_rdata_o = cfg_q;
      OFF_STAT:   host_rdata_o = DATA_W'(status);
      OFF_MASK:   host_rdata_o = sem_mask;
      OFF_SEM_LO: host_rdata_o = sem;
      OFF_SEM_HI: host_rdata_o = sem >> 8;
      default:    host_rdata_o = '0;
    endcase
    for (int i = 0; i < NUM_SLOTS; i++)
      if (host_addr_i == rep_off(i)) host_rdata_o = rep_full[i] ? rep_data[i] : '0;
  end

  assign cp_cmd_valid_o  = cmd_full;
  assign cp_reply_full_o = rep_full;

  AST_HOLD_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold && $past(hold) |-> cmd_full == '0 && rep_full == '0); // R7

  AST_BOOT_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    boot |=> rep_full == '1); // R8

  AST_CHAIN_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chain_fire |=> !armed_q && rep_full[CHAIN_SLOT]); // R9
endmodule

// File: tb/host_copro_mailbox_bench.sv
`timescale 1ns/1ps
module host_copro_mailbox_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [5:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [2:0]  cmd_valid, take = '0, post = '0, rep_full;
  logic [47:0] cmd_data, post_data = '0;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  host_copro_mailbox u_host_copro_mailbox (
    .clk_i(clk), .rst_ni(rst_n), .host_wr_i(wr), .host_rd_i(rd),
    .host_addr_i(addr), .host_wdata_i(wdata), .host_rdata_o(rdata),
    .cp_cmd_valid_o(cmd_valid), .cp_cmd_data_o(cmd_data), .cp_take_i(take),
    .cp_post_i(post), .cp_post_data_i(post_data), .cp_reply_full_o(rep_full)
  );

  task automatic chk(string req, logic [47:0] got, logic [47:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic host_wr(logic [5:0] a, logic [15:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic host_rd(logic [5:0] a, output logic [15:0] d);
    @(negedge clk); rd = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic peek(logic [5:0] a, output logic [15:0] d);
    @(negedge clk); addr = a;
    #1 d = rdata;
  endtask

  task automatic cp_post(int s, logic [15:0] d);
    @(negedge clk); post[s] = 1'b1; post_data[s*16 +: 16] = d;
    @(negedge clk); post = '0;
  endtask

  task automatic cp_take(int s);
    @(negedge clk); take[s] = 1'b1;
    @(negedge clk); take = '0;
  endtask

  task automatic t_reset();
    logic [15:0] v;
    peek(6'h0C, v); chk("R7 status after reset", v, 16'h0000);
    peek(6'h08, v); chk("R7 cfg after reset", v, 16'h0000);
    peek(6'h1C, v); chk("R7 sem after reset", v, 16'h0000);
    chk("R7 cmd valid after reset", cmd_valid, 3'b000);
    host_rd(6'h24, v); chk("R5 empty reply read", v, 16'h0000);
  endtask

  task automatic t_cmd();
    logic [15:0] v;
    host_wr(6'h20, 16'h1234);
    peek(6'h0C, v); chk("R1 status bit13", v, 16'h2000);
    chk("R1 slot0 data", cmd_data[15:0], 16'h1234);
    host_wr(6'h28, 16'hBEEF);
    peek(6'h0C, v); chk("R1 status bits13/14", v, 16'h6000);
    chk("R1 slot1 data", cmd_data[31:16], 16'hBEEF);
    host_wr(6'h20, 16'h5555);
    chk("R3 occupied slot kept", cmd_data[15:0], 16'h1234);
    cp_take(0);
    peek(6'h0C, v); chk("R2 take clears bit13", v, 16'h4000);
    host_wr(6'h30, 16'h00AA);
    chk("R1 slot2 valid", cmd_valid, 3'b110);
    chk("R1 slot2 data", cmd_data[47:32], 16'h00AA);
    cp_take(1); cp_take(2);
    chk("R2 all taken", cmd_valid, 3'b000);
  endtask

  task automatic t_reply();
    logic [15:0] v;
    cp_post(1, 16'hCAFE);
    peek(6'h0C, v); chk("R4 status bit11", v, 16'h0800);
    cp_post(1, 16'h1111);
    host_rd(6'h2C, v); chk("R5 post to full dropped", v, 16'hCAFE);
    peek(6'h0C, v); chk("R4 read clears bit11", v, 16'h0000);
    host_rd(6'h2C, v); chk("R5 second read empty", v, 16'h0000);
  endtask

  task automatic t_collide();
    logic [15:0] v;
    cp_post(0, 16'h0A0A);
    @(negedge clk);
    rd = 1'b1; addr = 6'h24; post[0] = 1'b1; post_data[15:0] = 16'h0B0B;
    #1 v = rdata;
    @(negedge clk); rd = 1'b0; post = '0;
    chk("R6 read returns old word", v, 16'h0A0A);
    chk("R6 slot empty after collision", rep_full, 3'b000);
    host_rd(6'h24, v); chk("R6 colliding post dropped", v, 16'h0000);
  endtask

  task automatic t_hold();
    logic [15:0] v;
    host_wr(6'h20, 16'h7777);
    cp_post(0, 16'h2222);
    host_wr(6'h08, 16'h0001);
    peek(6'h0C, v); chk("R7 hold clears slots", v, 16'h0000);
    host_wr(6'h20, 16'h3333);
    chk("R7 cmd write ignored in hold", cmd_valid, 3'b000);
    cp_post(1, 16'h4444);
    chk("R7 post ignored in hold", rep_full, 3'b000);
    peek(6'h08, v); chk("R7 cfg readback", v, 16'h0001);
  endtask

  task automatic t_boot();
    logic [15:0] v;
    host_wr(6'h08, 16'h0000);
    peek(6'h0C, v); chk("R8 boot fills replies", v, 16'h1C00);
    host_rd(6'h24, v); chk("R8 reply0 boot value", v, 16'h0001);
    host_rd(6'h2C, v); chk("R8 reply1 boot value", v, 16'h0001);
    host_rd(6'h34, v); chk("R8 reply2 boot value", v, 16'h0001);
    chk("R9 slot2 refilled", rep_full, 3'b100);
    host_rd(6'h34, v); chk("R9 chained value", v, 16'h0800);
    chk("R9 slot2 empty after chain read", rep_full, 3'b000);
    cp_post(2, 16'h0042);
    host_rd(6'h34, v); chk("R9 normal reply", v, 16'h0042);
    chk("R9 no second chain", rep_full, 3'b000);
  endtask

  task automatic t_sem();
    logic [15:0] v;
    host_wr(6'h14, 16'h00F0);
    peek(6'h14, v); chk("R10 mask readback", v, 16'h00F0);
    host_wr(6'h10, 16'h0030);
    peek(6'h1C, v); chk("R10 set ORs bits", v, 16'h0030);
    peek(6'h0C, v); chk("R11 masked set leaves bit9", v, 16'h0000);
    host_wr(6'h10, 16'h0102);
    peek(6'h1C, v); chk("R10 set accumulates", v, 16'h0132);
    peek(6'h0C, v); chk("R11 unmasked set raises bit9", v, 16'h0200);
    peek(6'h1D, v); chk("R10 high byte read", v, 16'h0001);
    host_wr(6'h18, 16'h0030);
    peek(6'h1C, v); chk("R10 clear written bits", v, 16'h0102);
    peek(6'h0C, v); chk("R11 bit9 kept while nonzero", v, 16'h0200);
    host_wr(6'h18, 16'h0102);
    peek(6'h1C, v); chk("R10 sem zero", v, 16'h0000);
    peek(6'h0C, v); chk("R11 bit9 cleared at zero", v, 16'h0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_cmd();
    t_reply();
    t_collide();
    t_hold();
    t_boot();
    t_sem();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule